// File: doc/BRIEF.md
# Four-Channel Prescaled Timer with Shared Interrupt

This block holds four independent 16-bit down-counting timers, all clocked by a single 4 MHz system clock. A free-running divide chain makes single-cycle tick enables at 2 MHz, 1 MHz, 500 kHz and 250 kHz. Each timer uses one of these ticks, chosen by its own two-bit field. An enabled timer decrements once per selected tick. When a tick arrives while its count is zero, the timer reloads from its reload register and raises its own status flag. The single interrupt output is high whenever any flagged timer also has its interrupt enable set.

Software programs the block through a plain register port of one write strobe, an address, write data and a combinational read-data bus. The control word packs one byte per timer. A status flag can be cleared in two ways. One is writing a zero into that flag's bit of the control word. The other is a write of any data to that timer's dedicated clear address. No data leaves or enters the block as a stream, so the port has no valid/ready pair. A write takes effect at the clock edge on which `reg_wr` is high.

Top module: `qtimer_unit`

## Requirements
- R1: After reset, the control word reads 0, every reload register reads 0 and `irq` is 0.
- R2: The prescale count starts at 0 when reset is released and advances once per clock. The tick for select code k (00, 01, 10, 11 = divide by 2, 4, 8, 16) is present in a cycle only when the low k+1 bits of that count are all ones.
- R3: The control word at address 0x00 holds timer n (n = 0..3) in bits 8n+7..8n. Within that byte, bit 0 is the status flag, bit 1 is enable, bit 2 is interrupt enable and bits 4:3 are the clock select. Bits 7:5 of each byte are stored and read back as written, and they have no effect.
- R4: A disabled timer does not count, keeps its count equal to its reload value and never sets its flag. Its first flag after it is enabled comes on the (reload+1)-th selected tick.
- R5: `irq` is the OR, over all four timers, of flag AND interrupt enable.
- R6: Writing the control word with 0 in a timer's status bit clears only that timer's flag. A 1 in that bit leaves the flag as it was.
- R7: A write of any data to address 0x20+4n clears the flag of timer n.
- R8: On a selected tick, an enabled timer with a nonzero count decrements by one. With a zero count it loads the reload value and sets its flag.
- R9: If a timer's flag is set by hardware and cleared by software in the same cycle, the flag ends up set.
- R10: The reload register of timer n is read and written at address 0x10+4n, using its low 16 bits. Clear addresses, unmapped addresses and addresses with bits 1:0 not zero read as 0, and writes to unmapped or misaligned addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 4 MHz system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| reg_addr | input | 6 | Byte address of the register being accessed |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Shared interrupt request |

## Verification
A wrong count shows up in the control word as a status flag that rises one or more ticks too early or too late. Because reloads are kept small, this happens within a few dozen cycles. A clear that catches the wrong timer, or a set that loses to a clear, changes the flag and the `irq` level in the cycle right after the edge. A prescaler slip shifts every later flag of the timers using the affected rate. The bench compares the addressed read value and `irq` against an independent cycle model on every cycle, so any such divergence is caught in the first cycle it reaches the ports.

// File: rtl/qtu_pkg.sv
package qtu_pkg;
  localparam int NUM_TMR   = 4;
  localparam int BYTE_W    = 8;
  localparam int ST_BIT    = 0;
  localparam int EN_BIT    = 1;
  localparam int IE_BIT    = 2;
  localparam int SEL_LO    = 3;
  localparam int SEL_W     = 2;
  localparam int NUM_RATES = 1 << SEL_W;

  typedef struct packed {
    logic [SEL_W-1:0] sel;
    logic             ie;
    logic             en;
  } tmr_cfg_t;

  typedef enum logic [1:0] {
    RGN_CTRL   = 2'd0,
    RGN_RELOAD = 2'd1,
    RGN_CLEAR  = 2'd2,
    RGN_NONE   = 2'd3
  } rgn_e;
endpackage

// File: rtl/qtu_prescaler.sv
module qtu_prescaler #(
  parameter int NUM_RATES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  output logic [NUM_RATES-1:0] tick
);
  logic [NUM_RATES-1:0] pre_q;

  always_ff @(posedge clk) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_q + 1'b1;
  end

  for (genvar k = 0; k < NUM_RATES; k++) begin : g_tick
    assign tick[k] = &pre_q[k:0];
  end

  for (genvar k = 1; k < NUM_RATES; k++) begin : g_nest
    AST_TICK_NESTED: assert property (@(posedge clk) disable iff (!rst_n)
      tick[k] |-> tick[k-1]); // R2
  end

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    tick[0] |=> !tick[0]); // R2
endmodule

// File: rtl/qtu_timer_chan.sv
module qtu_timer_chan #(
  parameter int CNT_W     = 16,
  parameter int NUM_RATES = 4,
  parameter int SEL_W     = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic [SEL_W-1:0]     sel,
  input  logic [CNT_W-1:0]     reload,
  input  logic [NUM_RATES-1:0] tick,
  input  logic                 sw_clr,
  output logic                 flag
);
  logic [CNT_W-1:0] cnt_q;
  logic             flag_q;
  logic             step;
  logic             at_zero;
  logic             hw_set;

  assign step    = en & tick[sel];
  assign at_zero = (cnt_q == '0);
  assign hw_set  = step & at_zero;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (!en)
        cnt_q <= reload;
      else if (step)
        cnt_q <= at_zero ? reload : cnt_q - 1'b1;
      flag_q <= hw_set | (flag_q & ~sw_clr);
    end
  end

  assign flag = flag_q;

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    hw_set |=> flag_q); // R9
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_clr && !hw_set) |=> !flag_q); // R6
  AST_RISE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(en)); // R4
  AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick[sel] && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R8
  AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick[sel] && cnt_q == '0) |=> (cnt_q == $past(reload))); // R8
endmodule

// File: rtl/qtu_regs.sv
module qtu_regs
  import qtu_pkg::*;
#(
  parameter int NUM_TMR = 4,
  parameter int CNT_W   = 16,
  parameter int ADDR_W  = 6,
  parameter int DATA_W  = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [DATA_W-1:0]       wdata,
  input  logic [NUM_TMR-1:0]      flags,
  output tmr_cfg_t                cfg    [NUM_TMR],
  output logic [CNT_W-1:0]        reload [NUM_TMR],
  output logic [NUM_TMR-1:0]      sw_clr,
  output logic [DATA_W-1:0]       rdata
);
  localparam int IDX_W = (NUM_TMR > 1) ? $clog2(NUM_TMR) : 1;

  function automatic logic [DATA_W-1:0] store_mask();
    logic [DATA_W-1:0] m;
    m = '1;
    for (int n = 0; n < NUM_TMR; n++) m[n*BYTE_W + ST_BIT] = 1'b0;
    return m;
  endfunction

  localparam logic [DATA_W-1:0] STORE_MASK = store_mask();

  logic [DATA_W-1:0] ctrl_q;
  logic [CNT_W-1:0]  reload_q [NUM_TMR];
  logic [IDX_W-1:0]  idx;
  logic              aligned;
  rgn_e              rgn;
  logic [DATA_W-1:0] flag_vec;

  assign idx     = addr[2 +: IDX_W];
  assign aligned = (addr[1:0] == 2'b00);

  always_comb begin
    rgn = RGN_NONE;
    if (aligned) begin
      unique case (addr[ADDR_W-1 -: 2])
        2'd0:    rgn = (idx == '0) ? RGN_CTRL : RGN_NONE;
        2'd1:    rgn = RGN_RELOAD;
        2'd2:    rgn = RGN_CLEAR;
        default: rgn = RGN_NONE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      for (int n = 0; n < NUM_TMR; n++) reload_q[n] <= '0;
    end else if (wr) begin
      if (rgn == RGN_CTRL)   ctrl_q        <= wdata & STORE_MASK;
      if (rgn == RGN_RELOAD) reload_q[idx] <= wdata[CNT_W-1:0];
    end
  end

  for (genvar n = 0; n < NUM_TMR; n++) begin : g_tmr
    assign cfg[n].en  = ctrl_q[n*BYTE_W + EN_BIT];
    assign cfg[n].ie  = ctrl_q[n*BYTE_W + IE_BIT];
    assign cfg[n].sel = ctrl_q[n*BYTE_W + SEL_LO +: SEL_W];
    assign reload[n]  = reload_q[n];
    assign sw_clr[n]  = wr & (((rgn == RGN_CTRL) & ~wdata[n*BYTE_W + ST_BIT]) |
                              ((rgn == RGN_CLEAR) & (idx == IDX_W'(n))));
  end

  always_comb begin
    flag_vec = '0;
    for (int n = 0; n < NUM_TMR; n++) flag_vec[n*BYTE_W + ST_BIT] = flags[n];
  end

  always_comb begin
    unique case (rgn)
      RGN_CTRL:   rdata = ctrl_q | flag_vec;
      RGN_RELOAD: rdata = DATA_W'(reload_q[idx]);
      default:    rdata = '0;
    endcase
  end

  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && rgn == RGN_CTRL) |=> $stable(ctrl_q)); // R10
  AST_CLEAR_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && rgn == RGN_CLEAR) |-> $onehot0(sw_clr)); // R7
endmodule

// File: rtl/qtimer_unit.sv
module qtimer_unit
  import qtu_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  tmr_cfg_t               cfg    [NUM_TMR];
  logic [CNT_W-1:0]       reload [NUM_TMR];
  logic [NUM_TMR-1:0]     sw_clr;
  logic [NUM_TMR-1:0]     flags;
  logic [NUM_TMR-1:0]     ie_vec;
  logic [NUM_RATES-1:0]   tick;

  qtu_prescaler #(.NUM_RATES(NUM_RATES)) u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick)
  );

  qtu_regs #(
    .NUM_TMR(NUM_TMR), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (reg_wr),
    .addr  (reg_addr),
    .wdata (reg_wdata),
    .flags (flags),
    .cfg   (cfg),
    .reload(reload),
    .sw_clr(sw_clr),
    .rdata (reg_rdata)
  );

  for (genvar n = 0; n < NUM_TMR; n++) begin : g_chan
    qtu_timer_chan #(.CNT_W(CNT_W), .NUM_RATES(NUM_RATES), .SEL_W(SEL_W)) u_chan (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (cfg[n].en),
      .sel   (cfg[n].sel),
      .reload(reload[n]),
      .tick  (tick),
      .sw_clr(sw_clr[n]),
      .flag  (flags[n])
    );
    assign ie_vec[n] = cfg[n].ie;
  end

  assign irq = |(flags & ie_vec);

  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flags != '0)); // R5
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (ie_vec == '0) |-> !irq); // R5
endmodule

// File: tb/qtimer_unit_tb.sv
`timescale 1ns/1ps
module qtimer_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  qtimer_unit u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  // Independent cycle model of the requirements
  logic [31:0] m_ctrl;
  logic [3:0]  m_flag;
  logic [15:0] m_cnt [4];
  logic [15:0] m_rel [4];
  logic [3:0]  m_pre;

  task automatic model_reset();
    m_ctrl = '0; m_flag = '0; m_pre = '0;
    for (int n = 0; n < 4; n++) begin m_cnt[n] = '0; m_rel[n] = '0; end
  endtask

  // kind: 0 ctrl, 1 reload, 2 clear, 3 none (R10 decode)
  function automatic int kind_of(logic [5:0] a);
    if (a[1:0] != 2'b00) return 3;
    if (a[5:4] == 2'd0) return (a[3:2] == 2'd0) ? 0 : 3;
    if (a[5:4] == 2'd1) return 1;
    if (a[5:4] == 2'd2) return 2;
    return 3;
  endfunction

  function automatic logic [31:0] exp_rdata(logic [5:0] a);
    logic [31:0] v;
    case (kind_of(a))
      0: begin
        v = m_ctrl;
        for (int n = 0; n < 4; n++) v[8*n] = m_flag[n];
        return v;
      end
      1: return {16'h0, m_rel[a[3:2]]};
      default: return '0;
    endcase
  endfunction

  function automatic logic exp_irq();
    logic r = 1'b0;
    for (int n = 0; n < 4; n++) r |= m_flag[n] & m_ctrl[8*n+2];
    return r;
  endfunction

  task automatic model_edge(logic wr, logic [5:0] a, logic [31:0] d);
    int k = kind_of(a);
    for (int n = 0; n < 4; n++) begin
      logic en = m_ctrl[8*n+1];
      int   sel = int'(m_ctrl[8*n+3 +: 2]);
      logic [3:0] mask = 4'((1 << (sel + 1)) - 1);
      logic tk = ((m_pre & mask) == mask);         // R2
      logic set = en & tk & (m_cnt[n] == 0);       // R8
      logic clr = wr & (((k == 0) & ~d[8*n]) | ((k == 2) & (a[3:2] == 2'(n)))); // R6 R7
      if (!en) m_cnt[n] = m_rel[n];                // R4
      else if (tk) m_cnt[n] = (m_cnt[n] == 0) ? m_rel[n] : m_cnt[n] - 1'b1;
      m_flag[n] = set | (m_flag[n] & ~clr);        // R9
    end
    if (wr && k == 0) begin
      m_ctrl = d;
      for (int n = 0; n < 4; n++) m_ctrl[8*n] = 1'b0;
    end
    if (wr && k == 1) m_rel[a[3:2]] = d[15:0];
    m_pre = m_pre + 1'b1;
  endtask

  task automatic check32(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %08h expected %08h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic check_outputs(logic [5:0] a);
    string lbl;
    case (kind_of(a))
      0: lbl = "R3/R8 control word";
      1: lbl = "R10 reload readback";
      default: lbl = "R10 unmapped or clear reads zero";
    endcase
    check32(lbl, reg_rdata, exp_rdata(a));
    check32("R5 irq", {31'h0, irq}, {31'h0, exp_irq()});
  endtask

  task automatic step(logic wr, logic [5:0] a, logic [31:0] d);
    reg_wr = wr; reg_addr = a; reg_wdata = d;
    #1;
    check_outputs(a);
    @(posedge clk);
    model_edge(wr, a, d);
    @(negedge clk);
  endtask

  task automatic idle(int n, logic [5:0] a);
    for (int i = 0; i < n; i++) step(1'b0, a, '0);
  endtask

  function automatic logic [5:0] rand_addr();
    int r = int'($urandom % 20);
    if (r < 9)  return 6'h00;
    if (r < 13) return 6'h10 + 6'(4 * ($urandom % 4));
    if (r < 17) return 6'h20 + 6'(4 * ($urandom % 4));
    if (r == 17) return 6'h04;
    if (r == 18) return 6'h30;
    return 6'h11;
  endfunction

  initial begin : watchdog
    #(1_000_000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd1234));
    model_reset();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset values
    check32("R1 control after reset", reg_rdata, 32'h0);
    reg_addr = 6'h14; #1;
    check32("R1 reload after reset", reg_rdata, 32'h0);
    check32("R1 irq after reset", {31'h0, irq}, 32'h0);
    reg_addr = 6'h00;

    // R8 R4: timer 0, reload 2, divide by 2, interrupt enabled
    step(1'b1, 6'h10, 32'hFFFF_0002);
    step(1'b1, 6'h00, 32'h0000_0006);
    idle(20, 6'h00);
    // R6: write 1 to status keeps flag, then 0 clears only timer 0
    step(1'b1, 6'h00, 32'h0000_0007);
    step(1'b1, 6'h00, 32'h0000_0006);
    // R3: reserved bits store and read back; timer 3 slowest rate
    step(1'b1, 6'h1C, 32'h0000_0003);
    step(1'b1, 6'h00, 32'hFE00_00E6 | 32'h1E00_0000);
    idle(40, 6'h00);
    // R7: clear register for timer 3 only
    step(1'b1, 6'h2C, 32'hDEAD_BEEF);
    idle(3, 6'h00);
    // R9: reload 0, every tick sets while clear is written every cycle
    step(1'b1, 6'h14, 32'h0);
    step(1'b1, 6'h00, 32'h0000_0601);
    for (int i = 0; i < 12; i++) step(1'b1, 6'h24, 32'h0);
    idle(4, 6'h00);
    // R10: unmapped and misaligned writes change nothing
    step(1'b1, 6'h04, 32'hFFFF_FFFF);
    step(1'b1, 6'h31, 32'hFFFF_FFFF);
    step(1'b1, 6'h12, 32'hFFFF_FFFF);
    idle(4, 6'h00);
    idle(2, 6'h10);

    // Random phase
    for (int i = 0; i < 4000; i++) begin
      logic [5:0]  a = rand_addr();
      logic        w = ($urandom % 10) < 3;
      logic [31:0] d = $urandom;
      if (kind_of(a) == 1) d = d % 6;
      if (kind_of(a) == 0 && ($urandom % 5) != 0) d |= 32'h0202_0202;
      step(w, a, d);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule